// File: doc/BRIEF.md
# Prescaled 56-bit Down-Counting Timer

This block is one timer channel with a 56-bit down-counter behind a small 32-bit register window. Software places a 56-bit interval into the block through two words. It picks a clock prescale, picks either continuous or single-shot operation, and then sets the enable bit. The counter loads the interval and steps toward zero once per prescaled tick. At zero it raises a sticky pending flag. In continuous operation it then reloads and carries on. In single-shot operation it clears its own enable and rests at zero.

Clearing enable freezes the count, and the frozen value stays readable. A manual reload strobe copies the interval into the counter without starting it. The 56-bit values are reached low word first. A low-word write is staged and only takes effect together with the high-word write. A low-word read of the count latches the upper bits, so the high-word read that follows matches it. An interrupt output follows the pending flag when interrupts are enabled. The pending flag is cleared by writing one to it.

Register words (addr): 0 control, 1 interval low, 2 interval high (bits 23:0), 3 count low, 4 count high (bits 23:0), 5 status (bit 0 pending). Control fields: bit 0 enable, bit 1 reload strobe, bits 6:4 prescale code, bit 7 single-shot, bit 8 interrupt enable. Read data is registered and appears the cycle after `rd_en`.

Top module: `wide_down_timer`

## Requirements
- R1: After reset every register word reads 0 and `irq` is 0.
- R2: A write to the interval low word (addr 1) leaves the committed interval unchanged. Reads of addr 1 still return the old value until the interval high word (addr 2) is written, and that write commits all 56 bits.
- R3: Setting enable (control bit 0) from 0 to 1 loads the interval N. Counting starts from it. With divide-by-1 and interrupts enabled, `irq` rises 2+(N+1) cycles after the clock edge that accepted the control write, because the expiry tick is the one taken while the count is already 0.
- R4: Prescale code c (control bits 6:4) gives one tick every 2^c cycles for c = 0..4. Reserved codes 5..7 behave as divide-by-16. A single-shot or first expiry then lands 2+(N+1)*D cycles after the enabling write.
- R5: In continuous mode (control bit 7 = 0) the counter reloads N at expiry and enable stays 1. Successive expiries are (N+1)*D cycles apart.
- R6: In single-shot mode (control bit 7 = 1) expiry clears enable, and the count stays at 0.
- R7: While enable is 0 and no reload is requested, the count holds its value.
- R8: Writing control bit 1 = 1 copies the interval into the counter on the next clock without starting it. The bit reads back as 0 after that clock.
- R9: Reading count low (addr 3) latches count bits 55:32. A later read of count high (addr 4) returns the latched bits, not the live ones.
- R10: Expiry sets status bit 0. Writing 1 to that bit clears it, and writing 0 has no effect.
- R11: `irq` is the registered AND of the pending flag and interrupt enable (control bit 8). With the enable at 0, `irq` stays 0 even while pending is set.
- R12: If an expiry and a clear write of the pending flag fall in the same cycle, the flag stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 3 | Word address of the register access |
| wr_en | input | 1 | Write strobe for `addr` |
| wr_data | input | 32 | Write data |
| rd_en | input | 1 | Read strobe; data valid the following cycle |
| rd_data | output | 32 | Registered read data |
| irq | output | 1 | Interrupt request, pending AND interrupt enable, registered |

## Verification
An expiry of the counter and a software write that clears the pending flag can land on the same clock edge. The bench first runs a continuous divide-by-1 timer and takes the expiry edge from the rise of `irq`. It then times a clear write so that it reaches the flag exactly one period later, on the next expiry edge. `irq` one cycle after that edge must still be 1, so the set has won. A second clear is placed off an expiry edge, and the `irq` sample one cycle after it must show 0.

// File: rtl/tmr56_pkg.sv
package tmr56_pkg;
  localparam int ADDR_W   = 3;
  localparam int PS_W     = 3;
  localparam int B_EN     = 0;
  localparam int B_RELOAD = 1;
  localparam int B_PS_LSB = 4;
  localparam int B_MODE   = 7;
  localparam int B_IE     = 8;

  typedef enum logic [ADDR_W-1:0] {
    A_CTRL   = 3'd0,
    A_IVL_LO = 3'd1,
    A_IVL_HI = 3'd2,
    A_CNT_LO = 3'd3,
    A_CNT_HI = 3'd4,
    A_STAT   = 3'd5
  } tmr_addr_e;

  typedef struct packed {
    logic            ie;
    logic            oneshot;
    logic [PS_W-1:0] ps;
    logic            en;
  } tmr_ctrl_t;
endpackage

// File: rtl/tmr_prescale.sv
module tmr_prescale #(
  parameter int CODE_W  = 3,
  parameter int MAX_LOG = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run,
  input  logic              restart,
  input  logic [CODE_W-1:0] code,
  output logic              tick
);
  logic [MAX_LOG-1:0] ps_cnt;
  logic [MAX_LOG-1:0] mask;
  int                 sh;

  // codes past the largest divider saturate at 2^MAX_LOG
  always_comb begin
    sh = (int'(code) > MAX_LOG) ? MAX_LOG : int'(code);
    for (int i = 0; i < MAX_LOG; i++) mask[i] = (i < sh);
  end

  assign tick = run && !restart && ((ps_cnt & mask) == mask);

  always_ff @(posedge clk) begin
    if (rst || !run || restart) ps_cnt <= '0;
    else                        ps_cnt <= ps_cnt + {{(MAX_LOG-1){1'b0}}, 1'b1};
  end
endmodule

// File: rtl/tmr_count.sv
module tmr_count #(
  parameter int CNT_W = 56
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             oneshot,
  input  logic             reload,
  input  logic             tick,
  input  logic [CNT_W-1:0] interval,
  output logic [CNT_W-1:0] cnt_q,
  output logic             start,
  output logic             expire
);
  logic en_q;
  logic load;
  logic at_zero;

  assign start   = en && !en_q;
  assign load    = start || reload;
  assign at_zero = (cnt_q == '0);
  assign expire  = en && tick && at_zero && !load;

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q  <= 1'b0;
      cnt_q <= '0;
    end else begin
      en_q <= en;
      if (load)
        cnt_q <= interval;
      else if (en && tick) begin
        if (at_zero) begin
          if (!oneshot) cnt_q <= interval;
        end else
          cnt_q <= cnt_q - {{(CNT_W-1){1'b0}}, 1'b1};
      end
    end
  end

  assert_load_on_start_R3: assert property (@(posedge clk) disable iff (rst)
    start |=> cnt_q == $past(interval));

  assert_hold_when_off_R7: assert property (@(posedge clk) disable iff (rst)
    (!en && !reload) |=> $stable(cnt_q));
endmodule

// File: rtl/tmr_regs.sv
module tmr_regs
  import tmr56_pkg::*;
#(
  parameter int CNT_W = 56,
  parameter int DW    = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic [DW-1:0]     wr_data,
  input  logic              rd_en,
  input  logic [CNT_W-1:0]  cnt,
  input  logic              expire,
  output tmr_ctrl_t         ctrl,
  output logic              reload_pend,
  output logic [CNT_W-1:0]  interval,
  output logic [DW-1:0]     rd_data,
  output logic              irq
);
  localparam int HI_W = CNT_W - DW;

  tmr_addr_e      a_e;
  logic           wr_ctrl;
  logic           wr_stat;
  logic           pend;
  logic [DW-1:0]  stage_lo;
  logic [HI_W-1:0] shadow;
  logic [DW-1:0]  ctrl_word;

  assign a_e     = tmr_addr_e'(addr);
  assign wr_ctrl = wr_en && (a_e == A_CTRL);
  assign wr_stat = wr_en && (a_e == A_STAT);

  always_comb begin
    ctrl_word                    = '0;
    ctrl_word[B_EN]              = ctrl.en;
    ctrl_word[B_RELOAD]          = reload_pend;
    ctrl_word[B_PS_LSB +: PS_W]  = ctrl.ps;
    ctrl_word[B_MODE]            = ctrl.oneshot;
    ctrl_word[B_IE]              = ctrl.ie;
  end

  // control word; a single-shot expiry has the last say on enable
  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl        <= '0;
      reload_pend <= 1'b0;
    end else begin
      reload_pend <= wr_ctrl && wr_data[B_RELOAD];
      if (wr_ctrl) begin
        ctrl.en      <= wr_data[B_EN];
        ctrl.ps      <= wr_data[B_PS_LSB +: PS_W];
        ctrl.oneshot <= wr_data[B_MODE];
        ctrl.ie      <= wr_data[B_IE];
      end
      if (expire && ctrl.oneshot) ctrl.en <= 1'b0;
    end
  end

  // interval: low word staged, committed by the high-word write
  always_ff @(posedge clk) begin
    if (rst) begin
      stage_lo <= '0;
      interval <= '0;
    end else if (wr_en) begin
      if (a_e == A_IVL_LO) stage_lo <= wr_data;
      if (a_e == A_IVL_HI) interval <= {wr_data[HI_W-1:0], stage_lo};
    end
  end

  // pending flag: set beats clear
  always_ff @(posedge clk) begin
    if (rst) begin
      pend <= 1'b0;
      irq  <= 1'b0;
    end else begin
      if (expire)                     pend <= 1'b1;
      else if (wr_stat && wr_data[0]) pend <= 1'b0;
      irq <= pend && ctrl.ie;
    end
  end

  // registered read port with high-bit snapshot
  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= '0;
      shadow  <= '0;
    end else if (rd_en) begin
      case (a_e)
        A_CTRL:   rd_data <= ctrl_word;
        A_IVL_LO: rd_data <= interval[DW-1:0];
        A_IVL_HI: rd_data <= {{(DW-HI_W){1'b0}}, interval[CNT_W-1:DW]};
        A_CNT_LO: begin
          rd_data <= cnt[DW-1:0];
          shadow  <= cnt[CNT_W-1:DW];
        end
        A_CNT_HI: rd_data <= {{(DW-HI_W){1'b0}}, shadow};
        A_STAT:   rd_data <= {{(DW-1){1'b0}}, pend};
        default:  rd_data <= '0;
      endcase
    end
  end

  assert_reload_selfclear_R8: assert property (@(posedge clk) disable iff (rst)
    (reload_pend && !wr_ctrl) |=> !reload_pend);

  assert_set_wins_R12: assert property (@(posedge clk) disable iff (rst)
    expire |=> pend);

  assert_oneshot_stops_R6: assert property (@(posedge clk) disable iff (rst)
    (expire && ctrl.oneshot) |=> !ctrl.en);
endmodule

// File: rtl/wide_down_timer.sv
module wide_down_timer #(
  parameter int CNT_W   = 56,
  parameter int DW      = 32,
  parameter int MAX_LOG = 4
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [tmr56_pkg::ADDR_W-1:0] addr,
  input  logic                        wr_en,
  input  logic [DW-1:0]               wr_data,
  input  logic                        rd_en,
  output logic [DW-1:0]               rd_data,
  output logic                        irq
);
  import tmr56_pkg::*;

  tmr_ctrl_t        ctrl;
  logic             reload_pend;
  logic [CNT_W-1:0] interval;
  logic [CNT_W-1:0] cnt;
  logic             start;
  logic             expire;
  logic             tick;

  tmr_regs #(.CNT_W(CNT_W), .DW(DW)) u_regs (
    .clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
    .rd_en(rd_en), .cnt(cnt), .expire(expire), .ctrl(ctrl),
    .reload_pend(reload_pend), .interval(interval), .rd_data(rd_data), .irq(irq)
  );

  tmr_prescale #(.CODE_W(PS_W), .MAX_LOG(MAX_LOG)) u_ps (
    .clk(clk), .rst(rst), .run(ctrl.en), .restart(start), .code(ctrl.ps), .tick(tick)
  );

  tmr_count #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .en(ctrl.en), .oneshot(ctrl.oneshot), .reload(reload_pend),
    .tick(tick), .interval(interval), .cnt_q(cnt), .start(start), .expire(expire)
  );
endmodule

// File: tb/test_wide_down_timer.sv
module test_wide_down_timer;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [2:0]  addr = '0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic        rd_en = 1'b0;
  logic [31:0] rd_data;
  logic        irq;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [31:0] exp_q[$];
  string       tag_q[$];
  logic        sb_flag = 1'b0;
  logic        seen = 1'b0, seen_sb = 1'b0;

  always #5 clk = ~clk;

  wide_down_timer i_wide_down_timer (
    .clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
    .rd_en(rd_en), .rd_data(rd_data), .irq(irq)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] expv);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, expv);
    end
  endtask

  // scoreboard monitor
  always @(posedge clk) begin
    seen    <= rd_en;
    seen_sb <= sb_flag;
  end
  always @(negedge clk) begin
    if (seen && seen_sb && exp_q.size() > 0) begin
      logic [31:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      chk(t, rd_data, e);
    end
  end

  task automatic wr(logic [2:0] a, logic [31:0] d);
    @(negedge clk); addr = a; wr_data = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd_chk(logic [2:0] a, logic [31:0] e, string t);
    @(negedge clk); addr = a; rd_en = 1'b1; sb_flag = 1'b1;
    exp_q.push_back(e); tag_q.push_back(t);
    @(negedge clk); rd_en = 1'b0; sb_flag = 1'b0;
  endtask

  task automatic rd_get(logic [2:0] a, output logic [31:0] v);
    @(negedge clk); addr = a; rd_en = 1'b1; sb_flag = 1'b0;
    @(negedge clk); rd_en = 1'b0;
    v = rd_data;
  endtask

  task automatic wait_irq(output int c);
    c = 0;
    do begin @(posedge clk); #1; c++; end while (!irq && c < 1000);
  endtask

  task automatic stop_and_clear();
    wr(3'd0, 32'h0);
    wr(3'd5, 32'h1);
    repeat (2) @(posedge clk);
  endtask

  initial begin
    #(10 * 200000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int c;
    logic [31:0] v;
    repeat (4) @(posedge clk);
    @(negedge clk); rst = 1'b0;

    // R1 reset state
    rd_chk(3'd0, 32'h0, "R1 ctrl");
    rd_chk(3'd5, 32'h0, "R1 status");
    rd_chk(3'd3, 32'h0, "R1 count");
    rd_chk(3'd1, 32'h0, "R1 interval");
    chk("R1 irq", {31'b0, irq}, 32'h0);

    // R2 staged interval
    wr(3'd1, 32'd3);
    rd_chk(3'd1, 32'h0, "R2 low staged");
    wr(3'd2, 32'h0);
    rd_chk(3'd1, 32'd3, "R2 low committed");
    rd_chk(3'd2, 32'h0, "R2 high");

    // R3 start at divide-by-1, N=3
    wr(3'd0, 32'h101);
    wait_irq(c);
    chk("R3 first expiry cycles", c, 32'd6);
    stop_and_clear();

    // R4 prescale codes, including reserved ones
    for (int code = 1; code < 8; code++) begin
      int d;
      d = (code > 4) ? 16 : (1 << code);
      wr(3'd0, 32'h101 | (code << 4));
      wait_irq(c);
      chk($sformatf("R4 code %0d cycles", code), c, 2 + 4 * d);
      stop_and_clear();
    end

    // R5 continuous period at divide-by-4
    wr(3'd0, 32'h121);
    wait_irq(c);
    chk("R5 first expiry", c, 32'd18);
    fork
      begin
        c = 0;
        do begin @(posedge clk); #1; c++; end while (irq && c < 1000);
        do begin @(posedge clk); #1; c++; end while (!irq && c < 1000);
      end
      wr(3'd5, 32'h1);
    join
    chk("R5 period", c, 32'd16);
    rd_chk(3'd0, 32'h121, "R5 enable kept");
    stop_and_clear();

    // R6 single-shot
    wr(3'd0, 32'h181);
    wait_irq(c);
    chk("R6 expiry cycles", c, 32'd6);
    rd_chk(3'd0, 32'h180, "R6 enable cleared");
    rd_chk(3'd3, 32'h0, "R6 count at zero");
    repeat (10) @(posedge clk);
    rd_chk(3'd3, 32'h0, "R6 count stays zero");
    stop_and_clear();

    // R11 interrupt gating, R10 pending flag
    wr(3'd0, 32'h081);
    begin
      logic any;
      any = 1'b0;
      for (int i = 0; i < 20; i++) begin @(posedge clk); #1; any |= irq; end
      chk("R11 irq masked", {31'b0, any}, 32'h0);
    end
    rd_chk(3'd5, 32'h1, "R10 pending set");
    wr(3'd5, 32'h0);
    rd_chk(3'd5, 32'h1, "R10 write zero ignored");
    wr(3'd5, 32'h1);
    rd_chk(3'd5, 32'h0, "R10 write one clears");
    wr(3'd0, 32'h0);

    // R7 pause holds the count
    wr(3'd1, 32'd1000);
    wr(3'd2, 32'd0);
    wr(3'd0, 32'h1);
    repeat (10) @(posedge clk);
    wr(3'd0, 32'h0);
    rd_get(3'd3, v);
    checks++;
    if (!(v < 32'd1000 && v > 32'd0)) begin
      errors++;
      $display("FAIL R7 count moved actual=%0d expected 1..999", v);
    end
    repeat (20) @(posedge clk);
    rd_chk(3'd3, v, "R7 frozen");

    // R8 reload strobe while stopped
    wr(3'd0, 32'h2);
    rd_chk(3'd3, 32'd1000, "R8 reload value");
    rd_chk(3'd0, 32'h0, "R8 strobe reads zero");
    repeat (5) @(posedge clk);
    rd_chk(3'd3, 32'd1000, "R8 no start");

    // R9 coherent high word
    wr(3'd1, 32'd2);
    wr(3'd2, 32'd1);
    wr(3'd0, 32'h1);
    rd_get(3'd3, v);
    repeat (6) @(posedge clk);
    rd_chk(3'd4, (v <= 32'd2) ? 32'd1 : 32'd0, "R9 snapshot high");
    stop_and_clear();

    // R12 expiry and clear in the same cycle, N=3 divide-by-1
    wr(3'd1, 32'd3);
    wr(3'd2, 32'd0);
    wr(3'd0, 32'h101);
    wait_irq(c);
    repeat (2) @(posedge clk);
    wr(3'd5, 32'h1);
    @(posedge clk); #1;
    chk("R12 set wins", {31'b0, irq}, 32'h1);
    wr(3'd5, 32'h1);
    @(posedge clk); #1;
    chk("R10 clear off expiry", {31'b0, irq}, 32'h0);
    stop_and_clear();

    repeat (3) @(posedge clk);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule